// File: doc/BRIEF.md
# Split-Operand Unsigned Multiplier

This block multiplies two unsigned operands of even width by cutting each operand into an upper half and a lower half. Four half-width products are formed at the same time. The product of the two upper halves is the high term. The product of the two lower halves is the low term. The middle term is the plain sum of the two mixed products (upper times lower, and lower times upper), so it needs no subtraction and does not wait for the other two terms. The three terms are then shifted into place and added.

The result goes into one output register. A valid strobe travels beside the operands and reaches the output one clock later. While the strobe is low, the register keeps its last product. The default width is 8 bits, which gives a 16-bit product. The same code also builds at other even widths, for example 4 bits with 2-bit halves.

Top module: `ksm_split_mult`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next state has valid_out = 0 and product = 0.
- R2: After every rising edge taken out of reset, valid_out equals the value valid_in had at that edge.
- R3: When valid_in is high at a rising edge, product takes the exact unsigned value op_a × op_b after that edge, for every pair of operand values.
- R4: The middle term is carried one bit wider than a half-width product, so the largest operands (all ones) give the full product without loss, for example 255 × 255 = 65025 at 8 bits.
- R5: When valid_in is low at a rising edge, product keeps its previous value whatever op_a and op_b hold.
- R6: At OP_W = 4 (2-bit halves), operands 11 and 6 give product 66.
- R7: At OP_W = 8, 17 × 24 gives 408 and 85 × 36 gives 3060.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Operands are present and should be captured |
| op_a | input | OP_W | Unsigned multiplicand |
| op_b | input | OP_W | Unsigned multiplier |
| valid_out | output | 1 | product holds a new result |
| product | output | 2*OP_W | Registered unsigned product |

## Verification
The bench runs every one of the 65536 operand pairs back to back. This shows that all four half products and the shifted sum are correct at each bit position, including pairs where one half is zero and pairs where every half is all ones, which is where the extra bit of the middle term matters. Separate runs apply the worked values and the maximum operands. Another run toggles the strobe with new operands on every cycle, so a stale or wrongly gated capture gives a result that differs from the reference queue. A second copy built at 4-bit width checks the small example, which catches any split offset that is tied to one width.

// File: rtl/ksm_pkg.sv
// Package: shared width helpers for the split-operand multiplier.
// Assumes operand widths are even so that both halves are equal.
package ksm_pkg;
    localparam int KSM_DEF_OP_W = 8;

    // Width of a product of two half operands.
    function automatic int ksm_half_prod_w(input int op_w);
        return op_w;
    endfunction

    // Width of the middle term: one bit more than a half product.
    function automatic int ksm_mid_w(input int op_w);
        return op_w + 1;
    endfunction
endpackage

// File: rtl/ksm_half_mult.sv
// Module: unsigned W x W multiplier built from shifted partial rows.
// Assumes unsigned inputs; purely combinational.
module ksm_half_mult #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int PW = 2 * W;

    logic [PW-1:0] rows [W];

    // One partial row per bit of b.
    for (genvar i = 0; i < W; i++) begin : g_row
        assign rows[i] = b[i] ? (PW'(a) << i) : '0;
    end

    // Add the partial rows.
    always_comb begin
        p = '0;
        for (int k = 0; k < W; k++) begin
            p = p + rows[k];
        end
    end

    // The sum of the rows must equal the arithmetic product (R3).
    always_comb begin
        a_r3_half_exact: assert (p == PW'(PW'(a) * PW'(b)));
    end
endmodule

// File: rtl/ksm_cross_term.sv
// Module: forms the middle term as the sum of the two mixed products.
// Assumes both inputs are half products of width PW; the output is PW+1 bits.
module ksm_cross_term #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] hi_lo,
    input  logic [PW-1:0] lo_hi,
    output logic [PW:0]   mid
);
    // Add the two mixed products with room for the carry.
    always_comb begin
        mid = {1'b0, hi_lo} + {1'b0, lo_hi};
    end

    // The widened sum must never wrap below either addend (R4).
    always_comb begin
        a_r4_no_overflow: assert (mid >= {1'b0, hi_lo} && mid >= {1'b0, lo_hi});
    end
endmodule

// File: rtl/ksm_recombine.sv
// Module: places the high, middle and low terms at their offsets and adds them.
// Assumes HW is the half-operand width; the high term is weighted 2^(2*HW).
module ksm_recombine #(
    parameter int HW = 4
) (
    input  logic [2*HW-1:0] hi_term,
    input  logic [2*HW:0]   mid_term,
    input  logic [2*HW-1:0] lo_term,
    output logic [4*HW-1:0] sum
);
    localparam int SW = 4 * HW;

    logic [SW-1:0] hi_sh;
    logic [SW-1:0] mid_sh;
    logic [SW-1:0] lo_ext;

    // Shift the terms into their positions.
    always_comb begin
        hi_sh  = SW'(hi_term) << (2 * HW);
        mid_sh = SW'(mid_term) << HW;
        lo_ext = SW'(lo_term);
    end

    // Final three-input add.
    always_comb begin
        sum = hi_sh + mid_sh + lo_ext;
    end
endmodule

// File: rtl/ksm_split_mult.sv
// Module: top of the split-operand multiplier with one output register.
// Assumes OP_W is even; reset is synchronous and active low.
module ksm_split_mult
    import ksm_pkg::*;
#(
    parameter int OP_W = KSM_DEF_OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic              valid_out,
    output logic [2*OP_W-1:0] product
);
    localparam int HW   = OP_W / 2;
    localparam int HPW  = ksm_half_prod_w(OP_W);
    localparam int MIDW = ksm_mid_w(OP_W);
    localparam int PRW  = 2 * OP_W;

    logic [HW-1:0]   a_half [2];
    logic [HW-1:0]   b_half [2];
    logic [HPW-1:0]  hp     [4];
    logic [MIDW-1:0] mid;
    logic [PRW-1:0]  comb_prod;

    assign a_half[0] = op_a[HW-1:0];
    assign a_half[1] = op_a[OP_W-1:HW];
    assign b_half[0] = op_b[HW-1:0];
    assign b_half[1] = op_b[OP_W-1:HW];

    // Four half products: index bit 1 picks the half of a, bit 0 the half of b.
    for (genvar g = 0; g < 4; g++) begin : g_hp
        ksm_half_mult #(.W(HW)) u_hm (
            .a (a_half[g / 2]),
            .b (b_half[g % 2]),
            .p (hp[g])
        );
    end

    ksm_cross_term #(.PW(HPW)) u_mid (
        .hi_lo (hp[2]),
        .lo_hi (hp[1]),
        .mid   (mid)
    );

    ksm_recombine #(.HW(HW)) u_rc (
        .hi_term  (hp[3]),
        .mid_term (mid),
        .lo_term  (hp[0]),
        .sum      (comb_prod)
    );

    // Output register: capture on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            product   <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                product <= comb_prod;
            end
        end
    end

    // R1: reset clears the outputs.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!valid_out && product == '0));

    // R2: strobe delayed by one clock.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (valid_out == $past(valid_in)));

    // R3: captured result equals the arithmetic product.
    a_r3_product_exact: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (product == PRW'(PRW'($past(op_a)) * PRW'($past(op_b)))));

    // R5: no capture while the strobe is low.
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(product));
endmodule

// File: tb/ksm_split_mult_bench.sv
module ksm_split_mult_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vin = 1'b0;
    logic [7:0]  a = '0;
    logic [7:0]  b = '0;
    logic        vout;
    logic [15:0] prod;

    logic        s_vout;
    logic [7:0]  s_prod;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    string cur_req = "R1";

    logic        m_valid = 1'b0;
    logic [15:0] m_prod = '0;

    always #2 clk = ~clk;

    ksm_split_mult #(.OP_W(8)) u_ksm_split_mult (
        .clk (clk), .rst_n (rst_n), .valid_in (vin),
        .op_a (a), .op_b (b), .valid_out (vout), .product (prod)
    );

    ksm_split_mult #(.OP_W(4)) u_small (
        .clk (clk), .rst_n (rst_n), .valid_in (1'b1),
        .op_a (4'd11), .op_b (4'd6), .valid_out (s_vout), .product (s_prod)
    );

    // Behavioural reference model of the output register.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_prod  <= '0;
        end else begin
            m_valid <= vin;
            if (vin) m_prod <= 16'(int'(a) * int'(b));
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (started) begin
            chk((cur_req == "R1") ? "R1" : "R2", int'(vout), int'(m_valid));
            chk(cur_req, int'(prod), int'(m_prod));
        end
    end

    task automatic drive(input int x, input int y, input bit v);
        @(posedge clk);
        #1;
        a = 8'(x);
        b = 8'(y);
        vin = v;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        cur_req = "R1";
        a = 8'hA5; b = 8'h5A; vin = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk("R1", int'(vout), 0);
        chk("R1", int'(prod), 0);
        rst_n = 1'b1;
        vin = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        // R6: small instance, operands 11 and 6.
        chk("R6", int'(s_prod), 66);
        chk("R6", int'(s_vout), 1);

        cur_req = "R7";
        drive(17, 24, 1'b1);
        drive(85, 36, 1'b1);
        drive(0, 0, 1'b0);
        @(negedge clk);
        chk("R7", int'(prod), 3060);

        cur_req = "R4";
        drive(255, 255, 1'b1);
        drive(255, 254, 1'b1);
        drive(240, 15, 1'b1);
        drive(15, 255, 1'b1);
        drive(0, 0, 1'b0);
        @(negedge clk);
        chk("R4", int'(prod), 3825);

        cur_req = "R5";
        drive(200, 200, 1'b1);
        for (int i = 1; i < 20; i++) drive(i * 13, i * 7 + 3, 1'b0);
        @(negedge clk);
        chk("R5", int'(prod), 40000);

        cur_req = "R2";
        for (int i = 0; i < 300; i++) drive((i * 37) % 256, (i * 91) % 256, ((i % 3) != 1));

        cur_req = "R3";
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) drive(x, y, 1'b1);
        end
        drive(0, 0, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        summary();
    end
endmodule